// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host that only has an 8-bit register port reach a wider internal register space with 16-bit word addresses and 32-bit data. The host stages the operands in a small window of byte registers: four data bytes, two address bytes and one control byte. A host write to the control byte starts exactly one internal transaction. The bridge keeps a private copy of the operands for that transaction, drives a request/acknowledge handshake toward the internal banks, and shows its progress through a busy bit that the host polls.

The internal space is divided into regions of 256 words, one per sub-block, and the upper address byte selects the region. An access outside the populated regions never reaches the internal bus. An access that is never acknowledged is abandoned after a bounded wait. In both cases the outcome is reported through an error code in the control byte.

Top module: `ind_reg_bridge`

## Requirements
- R1: After synchronous reset every window byte reads 0x00, busy is 0, the error code is 0 and `int_req` is low.
- R2: Host offsets 0x30..0x33 hold data bits 7:0, 15:8, 23:16, 31:24 and offsets 0x34/0x35 hold address bits 7:0/15:8; each reads back the last byte written to it. Offset 0x3F reads {busy in bit 7, read flag in bit 6, error code in bits 5:0}. Every other offset reads 0x00.
- R3: A host write to 0x3F while idle with bit 6 = 0 starts a write: busy reads 1 from the next cycle, and `int_req` rises with `int_we`=1 and with `int_addr`/`int_wdata` equal to the staged address and data. These hold steady until acknowledged.
- R4: A host write of bit 6 = 1 to 0x3F while idle starts a read with `int_we`=0. In the cycle where `int_ack` is sampled high, `int_rdata` is loaded into the data bytes, and busy reads 0 from the following cycle.
- R5: While `int_req` is high, `int_region` equals address bits 15:8, which lie in 0..9.
- R6: If address bits 15:8 exceed 9, `int_req` stays low, busy stays high for one cycle, then busy clears and the error code reads 0x01.
- R7: If `int_ack` does not arrive within 256 request cycles, `int_req` drops after exactly 256 cycles, busy clears and the error code reads 0x02.
- R8: The error code returns to 0x00 when the next access starts.
- R9: A host write to 0x3F while busy is ignored. It starts no second access and changes neither the read flag nor the current direction.
- R10: Host writes to the data or address bytes while busy update the window but do not change `int_addr` or `int_wdata` of the transaction in flight.
- R11: If a host data-byte write falls in the same cycle as the acknowledge that completes a read, the returned read data wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_addr | input | 8 | Host window offset for reads and writes |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Combinational read of the byte at `host_addr` |
| int_req | output | 1 | Internal transaction request |
| int_we | output | 1 | 1 = internal write, 0 = internal read |
| int_addr | output | 16 | Internal word address |
| int_wdata | output | 32 | Internal write data |
| int_region | output | 4 | Sub-block index decoded from the address |
| int_ack | input | 1 | Internal acknowledge, one cycle |
| int_rdata | input | 32 | Internal read data, valid with `int_ack` |

## Verification
Two functions can land in the same clock edge. A host write to a data byte can meet the acknowledge that completes a read and loads the returned word into the same byte. A host write to the control byte can also arrive while a transaction is still pending. The bench drives the acknowledge and a host write to byte 0x32 within a single cycle, then reads the byte back and expects the returned byte rather than the host byte. It also issues control and operand writes in mid-transaction and expects the internal bus to hold the original direction, address and data, with no second request after completion. All 256 upper-address values are swept with varying acknowledge delays, and the region, error code and busy timing are computed arithmetically.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
    localparam int BYTE_W     = 8;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 16;
    localparam int DATA_BYTES = DATA_W / BYTE_W;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int ERR_W      = 6;
    localparam int WIN_BASE   = 'h30;
    localparam int DATA_OFS   = WIN_BASE;
    localparam int ADDR_OFS   = WIN_BASE + DATA_BYTES;
    localparam int CTRL_OFS   = 'h3F;
    localparam int RW_BIT     = 6;

    localparam logic [ERR_W-1:0] ERR_NONE    = 6'h00;
    localparam logic [ERR_W-1:0] ERR_RANGE   = 6'h01;
    localparam logic [ERR_W-1:0] ERR_TIMEOUT = 6'h02;

    typedef enum logic [0:0] {ST_IDLE, ST_REQ} seq_state_e;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } txn_t;

    function automatic logic [BYTE_W-1:0] pack_ctrl(input logic busy, input logic rd,
                                                    input logic [ERR_W-1:0] err);
        return {busy, rd, err};
    endfunction
endpackage

// File: rtl/ibr_window.sv
module ibr_window
    import ibr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] ofs,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              load_rd,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [BYTE_W-1:0] ctrl_byte,
    output logic [DATA_W-1:0] data_word,
    output logic [ADDR_W-1:0] addr_word,
    output logic [BYTE_W-1:0] rdata
);
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            addr_q <= '0;
        end else begin
            for (int b = 0; b < DATA_BYTES; b++) begin
                if (load_rd)
                    data_q[b*BYTE_W +: BYTE_W] <= rd_word[b*BYTE_W +: BYTE_W];
                else if (wr_en && ofs == BYTE_W'(DATA_OFS + b))
                    data_q[b*BYTE_W +: BYTE_W] <= wdata;
            end
            for (int b = 0; b < ADDR_BYTES; b++) begin
                if (wr_en && ofs == BYTE_W'(ADDR_OFS + b))
                    addr_q[b*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < DATA_BYTES; b++)
            if (ofs == BYTE_W'(DATA_OFS + b)) rdata = data_q[b*BYTE_W +: BYTE_W];
        for (int b = 0; b < ADDR_BYTES; b++)
            if (ofs == BYTE_W'(ADDR_OFS + b)) rdata = addr_q[b*BYTE_W +: BYTE_W];
        if (ofs == BYTE_W'(CTRL_OFS)) rdata = ctrl_byte;
    end

    assign data_word = data_q;
    assign addr_word = addr_q;

    // R2: a plain host store to the low data byte lands in the window
    assert_byte_store_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !load_rd && ofs == BYTE_W'(DATA_OFS)) |=> (data_word[BYTE_W-1:0] == $past(wdata)));

    // R11: read return overrides a simultaneous host byte store
    assert_return_wins_R11: assert property (@(posedge clk) disable iff (rst)
        load_rd |=> (data_word == $past(rd_word)));
endmodule

// File: rtl/ibr_region_dec.sv
module ibr_region_dec
    import ibr_pkg::*;
#(
    parameter int REGION_COUNT = 10,
    localparam int REG_W = (REGION_COUNT > 1) ? $clog2(REGION_COUNT) : 1
)(
    input  logic [ADDR_W-1:0] addr,
    output logic [REG_W-1:0]  region,
    output logic              valid
);
    logic [BYTE_W-1:0] hi;

    always_comb begin
        hi     = addr[ADDR_W-1 -: BYTE_W];
        valid  = hi < BYTE_W'(REGION_COUNT);
        region = valid ? hi[REG_W-1:0] : '0;
    end
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
    import ibr_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 256,
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_rd,
    input  logic [DATA_W-1:0] data_word,
    input  logic [ADDR_W-1:0] addr_word,
    input  logic              addr_ok,
    input  logic              int_ack,
    output txn_t              txn,
    output logic              busy,
    output logic [ERR_W-1:0]  err,
    output logic              int_req,
    output logic              load_rd
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    seq_state_e       state_q;
    txn_t             txn_q;
    logic [ERR_W-1:0] err_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            txn_q   <= '0;
            err_q   <= ERR_NONE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_REQ;
                    txn_q   <= '{is_read: start_rd, addr: addr_word, data: data_word};
                    err_q   <= ERR_NONE;
                    cnt_q   <= '0;
                end
                ST_REQ: begin
                    if (!addr_ok) begin
                        state_q <= ST_IDLE;
                        err_q   <= ERR_RANGE;
                    end else if (int_ack) begin
                        state_q <= ST_IDLE;
                    end else if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        err_q   <= ERR_TIMEOUT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q == ST_REQ);
    assign int_req = busy && addr_ok;
    assign load_rd = int_req && int_ack && txn_q.is_read;
    assign txn     = txn_q;
    assign err     = err_q;

    // R3: an unanswered request keeps its operands until the wait ends
    assert_req_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (int_req && !int_ack && cnt_q != LAST) |=> (int_req && $stable(txn)));

    // R4: an acknowledge ends the access on the next cycle
    assert_ack_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (int_req && int_ack) |=> !busy);

    // R6: an out-of-range address ends with the range code
    assert_range_err_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !addr_ok) |=> (!busy && err == ERR_RANGE));

    // R7: the wait counter never passes its limit
    assert_wait_bound_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q <= LAST));

    // R8: a fresh access always begins with a clean error code
    assert_err_clean_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (err == ERR_NONE));

    // R9: busy only rises because of an accepted control write
    assert_busy_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
    import ibr_pkg::*;
#(
    parameter int REGION_COUNT   = 10,
    parameter int TIMEOUT_CYCLES = 256,
    localparam int REG_W = (REGION_COUNT > 1) ? $clog2(REGION_COUNT) : 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [7:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              int_req,
    output logic              int_we,
    output logic [15:0]       int_addr,
    output logic [31:0]       int_wdata,
    output logic [REG_W-1:0]  int_region,
    input  logic              int_ack,
    input  logic [31:0]       int_rdata
);
    txn_t              txn;
    logic              busy, addr_ok, load_rd, start;
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] data_word;
    logic [ADDR_W-1:0] addr_word;
    logic [BYTE_W-1:0] ctrl_byte;

    assign start     = host_wr && host_addr == BYTE_W'(CTRL_OFS);
    assign ctrl_byte = pack_ctrl(busy, txn.is_read, err);

    ibr_window u_win (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (host_wr),
        .ofs       (host_addr),
        .wdata     (host_wdata),
        .load_rd   (load_rd),
        .rd_word   (int_rdata),
        .ctrl_byte (ctrl_byte),
        .data_word (data_word),
        .addr_word (addr_word),
        .rdata     (host_rdata)
    );

    ibr_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_rd  (host_wdata[RW_BIT]),
        .data_word (data_word),
        .addr_word (addr_word),
        .addr_ok   (addr_ok),
        .int_ack   (int_ack),
        .txn       (txn),
        .busy      (busy),
        .err       (err),
        .int_req   (int_req),
        .load_rd   (load_rd)
    );

    ibr_region_dec #(.REGION_COUNT(REGION_COUNT)) u_dec (
        .addr   (txn.addr),
        .region (int_region),
        .valid  (addr_ok)
    );

    assign int_we    = !txn.is_read;
    assign int_addr  = txn.addr;
    assign int_wdata = txn.data;

    // R5: no request ever leaves for an unpopulated region
    assert_region_legal_R5: assert property (@(posedge clk) disable iff (rst)
        int_req |-> (int_addr[15:8] < 8'(REGION_COUNT)));

    // R10: host operand writes while busy leave the bus untouched
    assert_bus_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (int_req && !int_ack && host_wr && host_addr != 8'(CTRL_OFS)) |=>
            ($stable(int_addr) && $stable(int_wdata)));
endmodule

// File: tb/tb_ind_reg_bridge.sv
module tb_ind_reg_bridge;
    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr;
    logic [7:0]  host_addr, host_wdata, host_rdata;
    logic        int_req, int_we, int_ack;
    logic [15:0] int_addr;
    logic [31:0] int_wdata, int_rdata;
    logic [3:0]  int_region;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    ind_reg_bridge dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .int_req(int_req),
        .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
        .int_region(int_region), .int_ack(int_ack), .int_rdata(int_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [7:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [7:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic load_addr(input logic [15:0] a);
        hwr(8'h34, a[7:0]);
        hwr(8'h35, a[15:8]);
    endtask

    task automatic load_data(input logic [31:0] d);
        for (int b = 0; b < 4; b++) hwr(8'(8'h30 + b), d[b*8 +: 8]);
    endtask

    task automatic run_access(input bit rd, input logic [15:0] a, input logic [31:0] d,
                              input int dly, input logic [31:0] resp);
        logic [7:0] c;
        if (!rd) load_data(d);
        load_addr(a);
        hwr(8'h3F, rd ? 8'h40 : 8'h00);
        hrd(8'h3F, c);
        chk("R3 busy set and R8 error cleared", {24'h0, c[7], 1'b0, c[5:0]}, 32'h80);
        if (a[15:8] < 8'd10) begin
            chk("R3 req raised", int_req, 1);
            chk("R3/R4 direction", int_we, !rd);
            chk("R3 address", int_addr, a);
            if (!rd) chk("R3 write data", int_wdata, d);
            chk("R5 region", int_region, a[11:8]);
            repeat (dly) @(negedge clk);
            chk("R3 req held", int_req, 1);
            int_ack = 1'b1; int_rdata = resp;
            @(negedge clk);
            int_ack = 1'b0;
            hrd(8'h3F, c);
            chk("R4 done, R8 no error", c, {1'b0, rd, 6'h00});
            if (rd) for (int b = 0; b < 4; b++) begin
                hrd(8'(8'h30 + b), c);
                chk("R4 read data captured", c, resp[b*8 +: 8]);
            end
        end else begin
            chk("R6 no request", int_req, 0);
            @(negedge clk);
            hrd(8'h3F, c);
            chk("R6 range error", c, {1'b0, rd, 6'h01});
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] c;
        int cnt;
        rst = 1'b1; host_wr = 1'b0; host_addr = 8'h00; host_wdata = 8'h00;
        int_ack = 1'b0; int_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int o = 'h30; o <= 'h35; o++) begin
            hrd(8'(o), c);
            chk("R1 window zero", c, 0);
        end
        hrd(8'h3F, c);
        chk("R1 control zero", c, 0);
        chk("R1 no request", int_req, 0);

        // R2: readback of every staging byte, unused offsets read zero
        for (int o = 'h30; o <= 'h35; o++) hwr(8'(o), 8'(o * 7 + 3));
        for (int o = 'h30; o <= 'h35; o++) begin
            hrd(8'(o), c);
            chk("R2 readback", c, 8'(o * 7 + 3));
        end
        hrd(8'h36, c); chk("R2 unused offset", c, 0);
        hrd(8'h00, c); chk("R2 unused offset", c, 0);

        // R3/R5/R6/R8: write sweep over every upper address byte
        for (int h = 0; h < 256; h++)
            run_access(1'b0, {8'(h), 8'(h) ^ 8'h5A}, 32'(h) * 32'h0103_0507 + 32'h11,
                       h % 5, 32'h0);

        // R4: read sweep over each populated region
        for (int h = 0; h < 10; h++)
            for (int l = 0; l < 4; l++)
                run_access(1'b1, {8'(h), 8'(l * 61)}, 32'h0, (h + l) % 3,
                           {8'(h), 8'(l * 61), ~8'(l * 61), 8'(h) ^ 8'hC3});

        // R9/R10: control and operand writes while busy
        load_data(32'h1122_3344);
        load_addr(16'h0312);
        hwr(8'h3F, 8'h00);
        hwr(8'h3F, 8'h40);
        hwr(8'h30, 8'h99);
        hwr(8'h35, 8'h07);
        chk("R9 direction kept", int_we, 1);
        chk("R10 address kept", int_addr, 16'h0312);
        chk("R10 data kept", int_wdata, 32'h1122_3344);
        hrd(8'h30, c);
        chk("R10 window updated", c, 8'h99);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        hrd(8'h3F, c);
        chk("R9 read flag unchanged", c, 8'h00);
        repeat (3) @(negedge clk);
        chk("R9 no second request", int_req, 0);
        hrd(8'h3F, c);
        chk("R9 stays idle", c[7], 0);

        // R11: acknowledge of a read coincides with a host data byte write
        load_addr(16'h0100);
        hwr(8'h3F, 8'h40);
        int_ack = 1'b1; int_rdata = 32'hCAFE_F00D;
        host_wr = 1'b1; host_addr = 8'h32; host_wdata = 8'hEE;
        @(negedge clk);
        int_ack = 1'b0; host_wr = 1'b0;
        hrd(8'h32, c);
        chk("R11 read data wins", c, 8'hFE);

        // R7: no acknowledge at all
        load_addr(16'h0200);
        hwr(8'h3F, 8'h00);
        cnt = 0;
        while (int_req && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk("R7 request length", cnt, 256);
        hrd(8'h3F, c);
        chk("R7 timeout code", c, 8'h02);

        // R8: next access clears the timeout code
        load_addr(16'h0001);
        hwr(8'h3F, 8'h00);
        hrd(8'h3F, c);
        chk("R8 error cleared at start", c, 8'h80);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        hrd(8'h3F, c);
        chk("R8 clean finish", c, 8'h00);

        done = 1;
        summary();
        $finish;
    end
endmodule